// File: doc/BRIEF.md
# I2C Target Bridge to a 32-bit Register Port

This block lets an external I2C host reach a register space with 32-bit addresses and 32-bit data. The host addresses the bridge with its 7-bit target address. It then sends the four register-address bytes, least significant byte first.

- **Write:** the host follows the address with four data bytes, also least significant byte first. Once the last data byte has been acknowledged, the bridge issues one write request on its internal valid/ready port.
- **Read:** the host sends a repeated START with the read-direction address. The bridge issues one read request and shifts the returned word out on SDA, least significant byte first.

SCL and SDA are sampled through two-stage synchronisers on the system clock. START and STOP are recognised as SDA edges while SCL is high. SDA is open-drain: the bridge only ever pulls the line low, through `sda_oe_o`.

Top module: `i2c_reg_bridge`

## Requirements
- R1: After reset the bridge does not pull SDA low and no register request is pending.
- R2: An address byte whose upper seven bits equal `DEV_ADDR` (default 0x10, so 0x20 to write and 0x21 to read) is acknowledged by pulling SDA low during the ninth clock. Bit 0 of the address byte selects write (0) or read (1).
- R3: In a write frame, the bridge acknowledges each of the eight bytes that follow the address byte. The first four bytes form the register address and the next four form the data, each least significant byte first. For example, 20 00 04 00 70 09 B4 00 00 writes 0x0000B409 to 0x70000400. Exactly one write request carrying that address and data is raised after the eighth byte's acknowledge.
- R4: A STOP arriving before the eighth byte after the address byte ends the frame without any register request.
- R5: After the four address bytes, a repeated START with the read address raises one read request for the assembled register address. The returned word is then sent least significant byte first, most significant bit first within each byte.
- R6: Any byte the host reads after the fourth byte of a read is 0x00.
- R7: When the host does not acknowledge a data byte (SDA high in the ninth clock), the bridge releases SDA and leaves it released until the next START.
- R8: An address byte that does not match is not acknowledged. The bridge then ignores all bus traffic, and raises no request, until the next START.
- R9: A ninth byte after the address byte in a write frame is not acknowledged and raises no further request.
- R10: A request stays valid, with stable address and direction, until `reg_ready_i` is seen, and is dropped in the cycle after that handshake.
- R11: The level the bridge drives on SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| reg_valid_o | output | 1 | Register request valid |
| reg_write_o | output | 1 | 1 for a write request, 0 for a read request |
| reg_addr_o | output | 32 | Register address, assembled from the bus |
| reg_wdata_o | output | 32 | Write data, assembled from the bus |
| reg_ready_i | input | 1 | Register port accepts the request |
| reg_rdata_i | input | 32 | Read data, valid while ready is high on a read |

## Verification
The write path is tried with three patterns:
- the worked example word;
- an all-ones address paired with an all-zero data word;
- a word with distinct byte values.

A byte-order or bit-order slip shows up in at least one of them.

Reads are tried at two addresses against a register model that XORs the address with a constant, so every byte of the returned word differs. A read of six bytes separates the zero fill from a wrap-around of the word.

The frame-control patterns are:
- a frame cut short by STOP;
- a wrong target address followed by more bytes;
- a ninth write byte;
- extra clocks after a read that the host did not acknowledge.

These separate aborting, ignoring and refusing from silently issuing a request.

// File: rtl/i2c_reg_bridge.sv
module i2c_reg_bridge #(
  parameter logic [6:0] DEV_ADDR = 7'h10,
  parameter int NBYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic                  reg_valid_o,
  output logic                  reg_write_o,
  output logic [8*NBYTES-1:0]   reg_addr_o,
  output logic [8*NBYTES-1:0]   reg_wdata_o,
  input  logic                  reg_ready_i,
  input  logic [8*NBYTES-1:0]   reg_rdata_i
);
  localparam int W  = 8 * NBYTES;
  localparam int IW = $clog2(2 * NBYTES + 1);
  localparam logic [IW-1:0] IDX_DATA = IW'(NBYTES);
  localparam logic [IW-1:0] IDX_LAST = IW'(2 * NBYTES - 1);
  localparam logic [IW-1:0] IDX_END  = IW'(2 * NBYTES);

  typedef enum logic [1:0] {S_IDLE, S_DEV, S_RX, S_TX} st_t;

  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;
  wire        scl_s = scl_ff[1];
  wire        sda_s = sda_ff[1];
  wire        rise  = scl_s & ~scl_q;
  wire        fall  = ~scl_s & scl_q;
  wire        start = scl_s & scl_q & sda_q & ~sda_s;
  wire        stop  = scl_s & scl_q & ~sda_q & sda_s;

  st_t          st;
  logic [3:0]   bitcnt;
  logic [7:0]   sh;
  logic [IW-1:0] idx;
  logic         drv, nak, rd_mode;
  logic [W-1:0] adr_q, wd_q, rd_q;
  logic         valid, write;

  assign sda_oe_o    = drv;
  assign reg_valid_o = valid;
  assign reg_write_o = write;
  assign reg_addr_o  = adr_q;
  assign reg_wdata_o = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bitcnt <= '0;
      sh <= '0;
      idx <= '0;
      drv <= 1'b0;
      nak <= 1'b0;
      rd_mode <= 1'b0;
      adr_q <= '0;
      wd_q <= '0;
      rd_q <= '0;
      valid <= 1'b0;
      write <= 1'b0;
    end else begin
      if (valid && reg_ready_i) begin
        valid <= 1'b0;
        if (!write) rd_q <= reg_rdata_i;
      end
      if (start) begin
        st <= S_DEV;
        bitcnt <= '0;
        drv <= 1'b0;
        idx <= '0;
      end else if (stop) begin
        st <= S_IDLE;
        drv <= 1'b0;
      end else if (st != S_IDLE) begin
        if (rise) begin
          bitcnt <= bitcnt + 4'd1;
          if (st != S_TX && bitcnt < 4'd8) sh <= {sh[6:0], sda_s};
          if (st == S_TX && bitcnt == 4'd8) nak <= sda_s;
        end
        if (fall) begin
          if (st == S_TX) begin
            if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
              sh  <= {sh[6:0], 1'b0};
              drv <= ~sh[6];
            end else if (bitcnt == 4'd8) begin
              drv <= 1'b0;
            end else if (bitcnt == 4'd9) begin
              bitcnt <= '0;
              if (nak) st <= S_IDLE;
              else begin
                sh   <= rd_q[7:0];
                rd_q <= rd_q >> 8;
                drv  <= ~rd_q[7];
              end
            end
          end else if (bitcnt == 4'd8) begin
            if (st == S_DEV) begin
              if (sh[7:1] == DEV_ADDR) begin
                drv <= 1'b1;
                nak <= 1'b0;
                rd_mode <= sh[0];
                if (sh[0]) begin
                  valid <= 1'b1;
                  write <= 1'b0;
                end
              end else begin
                nak <= 1'b1;
              end
            end else if (idx < IDX_END) begin
              drv <= 1'b1;
              nak <= 1'b0;
              idx <= idx + 1'b1;
              if (idx < IDX_DATA) adr_q <= {sh, adr_q[W-1:8]};
              else                wd_q  <= {sh, wd_q[W-1:8]};
              if (idx == IDX_LAST) begin
                valid <= 1'b1;
                write <= 1'b1;
              end
            end else begin
              nak <= 1'b1;
            end
          end else if (bitcnt == 4'd9) begin
            drv <= 1'b0;
            bitcnt <= '0;
            if (nak) st <= S_IDLE;
            else if (st == S_DEV && rd_mode) begin
              st   <= S_TX;
              sh   <= rd_q[7:0];
              rd_q <= rd_q >> 8;
              drv  <= ~rd_q[7];
            end else if (st == S_DEV) begin
              st <= S_RX;
            end
          end
        end
      end
    end
  end
endmodule

module i2c_reg_bridge_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe_o,
  input logic        reg_valid_o,
  input logic        reg_write_o,
  input logic        reg_ready_i,
  input logic [31:0] reg_addr_o
);
  a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid_o && !reg_ready_i |=> reg_valid_o && $stable(reg_write_o) && $stable(reg_addr_o));

  a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid_o && reg_ready_i |=> !reg_valid_o);

  a_r11_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    scl_i && $past(scl_i) |-> $stable(sda_oe_o));

  a_r3_request_in_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_valid_o) |-> !scl_i);
endmodule

bind i2c_reg_bridge i2c_reg_bridge_sva u_sva (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .reg_valid_o(reg_valid_o), .reg_write_o(reg_write_o),
  .reg_ready_i(reg_ready_i), .reg_addr_o(reg_addr_o)
);

// File: tb/i2c_reg_bridge_tb.sv
module i2c_reg_bridge_tb;
  localparam int Q = 16;
  localparam logic [31:0] RMASK = 32'h5A5A_C3C3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, valid, wr, rdy;
  logic [31:0] addr, wdata, rdata;
  wire sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_reg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .reg_valid_o(valid), .reg_write_o(wr), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_ready_i(rdy), .reg_rdata_i(rdata)
  );

  always_ff @(posedge clk) rdy <= valid && !rdy;
  assign rdata = addr ^ RMASK;

  typedef struct packed { logic w; logic [31:0] a; logic [31:0] d; } item_t;
  item_t exp_q[$];
  int total = 0, bad = 0, viol = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // scoreboard monitor: R3 R5 R10
  always @(negedge clk) begin
    if (rst_n && valid && rdy) begin
      if (exp_q.size() == 0) chk(0, "R4/R8/R9 unexpected request", addr, 32'h0);
      else begin
        item_t e;
        e = exp_q.pop_front();
        chk(wr == e.w, e.w ? "R3 direction" : "R5 direction", {31'b0, wr}, {31'b0, e.w});
        chk(addr == e.a, e.w ? "R3 address" : "R5 address", addr, e.a);
        if (e.w) chk(wdata == e.d, "R3 data", wdata, e.d);
      end
    end
  end

  logic scl_p = 1'b1, oe_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_p && sda_oe != oe_p) viol++;
    scl_p <= scl;
    oe_p  <= sda_oe;
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq(); endtask
  task automatic bstop(); sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(); endtask
  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1; wq(); wq(); scl = 0; wq();
    end
    sda_m = 1; wq(); scl = 1; wq(); ack = ~sda_line; wq(); scl = 0; wq();
  endtask
  task automatic rbyte(input bit nack, output logic [7:0] b, output int drv_cnt);
    sda_m = 1; b = '0; drv_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1; wq(); b = {b[6:0], sda_line}; wq(); scl = 0; wq();
    end
    sda_m = nack; wq(); scl = 1; wq(); drv_cnt = sda_oe; wq(); scl = 0; wq();
    sda_m = 1;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    bit ack;
    exp_q.push_back({1'b1, a, d});
    bstart();
    wbyte(8'h20, ack); chk(ack, "R2 write address ack", {31'b0, ack}, 32'd1);
    for (int i = 0; i < 4; i++) begin
      wbyte(a[8*i +: 8], ack); chk(ack, "R3 address byte ack", {31'b0, ack}, 32'd1);
    end
    for (int i = 0; i < 4; i++) begin
      wbyte(d[8*i +: 8], ack); chk(ack, "R3 data byte ack", {31'b0, ack}, 32'd1);
    end
    bstop();
  endtask

  task automatic do_read(input logic [31:0] a, input int n);
    bit ack; logic [7:0] b; int dc;
    logic [31:0] w;
    w = a ^ RMASK;
    bstart();
    wbyte(8'h20, ack); chk(ack, "R2 address ack", {31'b0, ack}, 32'd1);
    for (int i = 0; i < 4; i++) wbyte(a[8*i +: 8], ack);
    exp_q.push_back({1'b0, a, 32'h0});
    bstart();
    wbyte(8'h21, ack); chk(ack, "R2 read address ack", {31'b0, ack}, 32'd1);
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, b, dc);
      if (i < 4) chk(b == w[8*i +: 8], "R5 read byte", {24'b0, b}, {24'b0, w[8*i +: 8]});
      else       chk(b == 8'h00, "R6 read beyond word", {24'b0, b}, 32'h0);
    end
    chk(sda_oe == 1'b0, "R7 released after NACK", {31'b0, sda_oe}, 32'd0);
    bstop();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    bit ack;
    logic [7:0] b;
    int dc, seen;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0, "R1 SDA released", {31'b0, sda_oe}, 32'd0);
    chk(valid == 0, "R1 no request", {31'b0, valid}, 32'd0);

    do_write(32'h7000_0400, 32'h0000_B409);
    do_write(32'hFFFF_FFFF, 32'h0000_0000);
    do_write(32'h1234_5678, 32'h89AB_CDEF);

    do_read(32'h7000_0400, 4);
    do_read(32'hDEAD_BEEC, 4);
    do_read(32'h0102_0304, 6);

    // R7: clocks after NACK must see no drive
    bstart();
    wbyte(8'h20, ack);
    for (int i = 0; i < 4; i++) wbyte(8'h10 + 8'(i), ack);
    exp_q.push_back({1'b0, 32'h1312_1110, 32'h0});
    bstart();
    wbyte(8'h21, ack);
    rbyte(1'b1, b, dc);
    seen = 0;
    for (int i = 0; i < 2; i++) begin
      rbyte(1'b0, b, dc);
      if (b != 8'hFF || dc != 0) seen++;
    end
    chk(seen == 0, "R7 no drive after NACK", 32'(seen), 32'd0);
    bstop();

    // R4: abort after six bytes
    bstart();
    wbyte(8'h20, ack);
    for (int i = 0; i < 6; i++) wbyte(8'hA0 + 8'(i), ack);
    bstop();
    wq(); wq();
    chk(exp_q.size() == 0, "R4 no request on early STOP", 32'(exp_q.size()), 32'd0);

    // R8: wrong address then traffic
    bstart();
    wbyte(8'h22, ack); chk(!ack, "R8 mismatch NACK", {31'b0, ack}, 32'd0);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      wbyte(8'h00, ack);
      if (ack) seen++;
    end
    chk(seen == 0, "R8 bus ignored after mismatch", 32'(seen), 32'd0);
    bstop();

    // R9: ninth byte refused
    exp_q.push_back({1'b1, 32'hCAFE_0010, 32'h5555_AAAA});
    bstart();
    wbyte(8'h20, ack);
    for (int i = 0; i < 4; i++) wbyte(8'(32'hCAFE_0010 >> (8*i)), ack);
    for (int i = 0; i < 4; i++) wbyte(8'(32'h5555_AAAA >> (8*i)), ack);
    wbyte(8'h77, ack); chk(!ack, "R9 ninth byte NACK", {31'b0, ack}, 32'd0);
    bstop();

    do_write(32'h0000_0004, 32'h0000_0001);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected requests seen", 32'(exp_q.size()), 32'd0);
    chk(viol == 0, "R11 SDA steady while SCL high", 32'(viol), 32'd0);
    chk(valid == 0, "R10 request dropped", {31'b0, valid}, 32'd0);
    finish_up();
  end
endmodule